// File: doc/BRIEF.md
# Two-Bank Interrupt Aggregation Controller

This block gathers up to 64 level-style interrupt requests from peripherals and merges them into a single request line for a processor. The requests arrive in two banks, a low bank and a high bank, each `BANK_W` bits wide. Input i of a bank lands in bit i of that bank's pending, mask and acknowledge registers. Every input passes through a synchronizer before use. A bank's pending bit is set when its synchronized input rises and is cleared when that input falls. Software can also drop a pending bit by writing a one to the bank's acknowledge register. An input that stays high after an acknowledge stays cleared until it goes low and rises again.

Software reaches the registers through a plain port with a byte address, a write strobe with data and a read strobe. The register window covers 0x100 bytes. Read data is registered: it appears on the clock edge that samples the read strobe and holds until the next read. The status registers return the pending bits already ANDed with the bank's mask. The processor line is high whenever any pending bit in either bank is also enabled. It is updated in the same cycle as the register change that causes it.

Top module: `irq_agg_top`

## Requirements
- R1: After reset, all pending and mask bits are zero, `cpu_irq_o` is low and `reg_rd_data_o` reads zero.
- R2: A rising input on bit i of a bank sets pending bit i of that bank. With the default two synchronizer stages, the bit is set on the third rising clock edge after the input changes. Bit i of `src_lo_i` maps to bit i of the low-bank registers, and bit i of `src_hi_i` maps to bit i of the high-bank registers.
- R3: A falling input clears its pending bit with the same latency as R2.
- R4: A read of offset 0x10 returns the high-bank pending bits ANDed with the high-bank mask. A read of offset 0x20 does the same for the low bank.
- R5: The mask registers are at offset 0x14 (high bank) and offset 0x24 (low bank). A write loads the full mask value, and a read returns the value last written.
- R6: A write to offset 0x18 (high bank) or 0x28 (low bank) clears every pending bit whose write-data bit is 1. An input that is still high stays cleared until it falls and rises again.
- R7: If a rising input and an acknowledge write hit the same bit on the same clock edge, the bit ends up set.
- R8: `cpu_irq_o` is the OR over both banks of (pending AND mask). It reflects a mask write, an acknowledge write or an input change in the cycle right after the edge that registers the change.
- R9: Reads of the acknowledge registers, of offset 0x2c and of unmapped offsets return zero. Writes to offset 0x2c and to unmapped offsets change no state.
- R10: `reg_rd_data_o` changes only on an edge where `reg_rd_en_i` is high. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lo_i | input | BANK_W | Low-bank interrupt inputs (asynchronous) |
| src_hi_i | input | BANK_W | High-bank interrupt inputs (asynchronous) |
| reg_addr_i | input | ADDR_W | Byte offset within the register window |
| reg_wr_en_i | input | 1 | Write strobe |
| reg_wr_data_i | input | DATA_W | Write data |
| reg_rd_en_i | input | 1 | Read strobe |
| reg_rd_data_o | output | DATA_W | Registered read data |
| cpu_irq_o | output | 1 | Combined interrupt request to the processor |

## Verification
The bench places an acknowledge write on exactly the edge where a new rising input is registered. A design that let the clear win would lose that interrupt. The bench also acknowledges an input that stays high and checks that no pending bit reappears. A pending bit modelled as a plain copy of the input level would set itself again at once. Mask writes that turn the line off and on are checked in the very next cycle, so a design with an extra register stage on the line would fail. Writes to the reserved offset and to unmapped offsets are followed by mask read-backs, and reads of the acknowledge and unmapped offsets must return zero, which catches decoders that alias offsets or leak stale read data.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int NUM_BANKS = 2;
   localparam int BANK_LO   = 0;
   localparam int BANK_HI   = 1;
   localparam int WIN_BYTES = 256;

   localparam logic [7:0] OFF_STAT_HI = 8'h10;
   localparam logic [7:0] OFF_MASK_HI = 8'h14;
   localparam logic [7:0] OFF_ACK_HI  = 8'h18;
   localparam logic [7:0] OFF_STAT_LO = 8'h20;
   localparam logic [7:0] OFF_MASK_LO = 8'h24;
   localparam logic [7:0] OFF_ACK_LO  = 8'h28;
   localparam logic [7:0] OFF_NOP     = 8'h2C;

   typedef enum logic [2:0] {
      KIND_NONE,
      KIND_STAT,
      KIND_MASK,
      KIND_ACK,
      KIND_NOP
   } reg_kind_e;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] src_i,
   output logic [W-1:0] rise_o,
   output logic [W-1:0] fall_o
);
   localparam int LAST = STAGES - 1;

   logic [STAGES-1:0][W-1:0] chain_q;
   logic [W-1:0]             last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= '0;
      end else begin
         chain_q[0] <= src_i;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
         last_q <= chain_q[LAST];
      end
   end

   assign rise_o = chain_q[LAST] & ~last_q;
   assign fall_o = last_q & ~chain_q[LAST];
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] rise_i,
   input  logic [W-1:0] fall_i,
   input  logic         ack_we_i,
   input  logic         mask_we_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] pend_o,
   output logic [W-1:0] mask_o
);
   logic [W-1:0] pend_q;
   logic [W-1:0] mask_q;
   logic [W-1:0] drop;

   assign drop = fall_i | (ack_we_i ? wdata_i : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         mask_q <= '0;
      end else begin
         pend_q <= (pend_q & ~drop) | rise_i;
         if (mask_we_i) begin
            mask_q <= wdata_i;
         end
      end
   end

   assign pend_o = pend_q;
   assign mask_o = mask_q;
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
   import irq_agg_pkg::*;
#(
   parameter int BANK_W = 32,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [ADDR_W-1:0]                 addr_i,
   input  logic                              wr_en_i,
   input  logic                              rd_en_i,
   input  logic [NUM_BANKS-1:0][BANK_W-1:0]  pend_i,
   input  logic [NUM_BANKS-1:0][BANK_W-1:0]  mask_i,
   output logic [NUM_BANKS-1:0]              ack_we_o,
   output logic [NUM_BANKS-1:0]              mask_we_o,
   output logic [DATA_W-1:0]                 rd_data_o
);
   reg_kind_e   kind;
   logic        bank;
   logic [DATA_W-1:0] rd_q;

   always_comb begin
      kind = KIND_NONE;
      bank = 1'b0;
      case (addr_i)
         ADDR_W'(OFF_STAT_HI): begin kind = KIND_STAT; bank = 1'b1; end
         ADDR_W'(OFF_MASK_HI): begin kind = KIND_MASK; bank = 1'b1; end
         ADDR_W'(OFF_ACK_HI):  begin kind = KIND_ACK;  bank = 1'b1; end
         ADDR_W'(OFF_STAT_LO): kind = KIND_STAT;
         ADDR_W'(OFF_MASK_LO): kind = KIND_MASK;
         ADDR_W'(OFF_ACK_LO):  kind = KIND_ACK;
         ADDR_W'(OFF_NOP):     kind = KIND_NOP;
         default:              kind = KIND_NONE;
      endcase
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_we
      assign ack_we_o[b]  = wr_en_i && (kind == KIND_ACK)  && (bank == b[0]);
      assign mask_we_o[b] = wr_en_i && (kind == KIND_MASK) && (bank == b[0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= '0;
      end else if (rd_en_i) begin
         case (kind)
            KIND_STAT: rd_q <= DATA_W'(pend_i[bank] & mask_i[bank]);
            KIND_MASK: rd_q <= DATA_W'(mask_i[bank]);
            default:   rd_q <= '0;
         endcase
      end
   end

   assign rd_data_o = rd_q;
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
   import irq_agg_pkg::*;
#(
   parameter int BANK_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] src_lo_i,
   input  logic [BANK_W-1:0] src_hi_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic              reg_wr_en_i,
   input  logic [DATA_W-1:0] reg_wr_data_i,
   input  logic              reg_rd_en_i,
   output logic [DATA_W-1:0] reg_rd_data_o,
   output logic              cpu_irq_o
);
   if (BANK_W < 1 || BANK_W > DATA_W) begin : g_bad_width
      $error("BANK_W must lie in 1..DATA_W");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must cover the 0x100-byte window");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_BANKS-1:0][BANK_W-1:0] src_b;
   logic [NUM_BANKS-1:0][BANK_W-1:0] rise_b;
   logic [NUM_BANKS-1:0][BANK_W-1:0] fall_b;
   logic [NUM_BANKS-1:0][BANK_W-1:0] pend_b;
   logic [NUM_BANKS-1:0][BANK_W-1:0] en_b;
   logic [NUM_BANKS-1:0]             ack_we;
   logic [NUM_BANKS-1:0]             mask_we;
   logic [NUM_BANKS-1:0]             bank_req;
   logic [BANK_W-1:0]                wdata_bank;

   assign src_b[BANK_LO] = src_lo_i;
   assign src_b[BANK_HI] = src_hi_i;
   assign wdata_bank     = reg_wr_data_i[BANK_W-1:0];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      irq_edge_sync #(.W(BANK_W), .STAGES(SYNC_STAGES)) sync_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .src_i  (src_b[b]),
         .rise_o (rise_b[b]),
         .fall_o (fall_b[b])
      );

      irq_pend_bank #(.W(BANK_W)) bank_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .rise_i    (rise_b[b]),
         .fall_i    (fall_b[b]),
         .ack_we_i  (ack_we[b]),
         .mask_we_i (mask_we[b]),
         .wdata_i   (wdata_bank),
         .pend_o    (pend_b[b]),
         .mask_o    (en_b[b])
      );

      assign bank_req[b] = |(pend_b[b] & en_b[b]);
   end

   irq_reg_port #(.BANK_W(BANK_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) port_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_i    (reg_addr_i),
      .wr_en_i   (reg_wr_en_i),
      .rd_en_i   (reg_rd_en_i),
      .pend_i    (pend_b),
      .mask_i    (en_b),
      .ack_we_o  (ack_we),
      .mask_we_o (mask_we),
      .rd_data_o (reg_rd_data_o)
   );

   assign cpu_irq_o = |bank_req;
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
   import irq_agg_pkg::*;
#(
   parameter int BANK_W = 32,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic [ADDR_W-1:0]                reg_addr_i,
   input logic                             reg_wr_en_i,
   input logic [DATA_W-1:0]                reg_wr_data_i,
   input logic                             reg_rd_en_i,
   input logic [DATA_W-1:0]                reg_rd_data_o,
   input logic                             cpu_irq_o,
   input logic [NUM_BANKS-1:0][BANK_W-1:0] pend_b,
   input logic [NUM_BANKS-1:0][BANK_W-1:0] en_b,
   input logic [NUM_BANKS-1:0][BANK_W-1:0] rise_b
);
   AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en_i && reg_addr_i == ADDR_W'(OFF_MASK_HI)) |=> en_b[BANK_HI] == $past(reg_wr_data_i[BANK_W-1:0])); // R5

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en_i && reg_addr_i == ADDR_W'(OFF_ACK_HI) && rise_b[BANK_HI] == '0)
      |=> (pend_b[BANK_HI] & $past(reg_wr_data_i[BANK_W-1:0])) == '0); // R6

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_b[BANK_LO] != '0) |=> (pend_b[BANK_LO] & $past(rise_b[BANK_LO])) == $past(rise_b[BANK_LO])); // R7

   AST_QUIET_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (en_b == '0) |-> !cpu_irq_o); // R8

   AST_STAT_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_en_i && reg_addr_i == ADDR_W'(OFF_STAT_LO))
      |=> reg_rd_data_o == $past(DATA_W'(pend_b[BANK_LO] & en_b[BANK_LO]))); // R4

   AST_NOP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en_i && reg_addr_i == ADDR_W'(OFF_NOP)) |=> $stable(en_b)); // R9

   AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_en_i && reg_addr_i == ADDR_W'(OFF_ACK_LO)) |=> reg_rd_data_o == '0); // R9

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd_en_i |=> $stable(reg_rd_data_o)); // R10
endmodule

bind irq_agg_top irq_agg_chk #(.BANK_W(BANK_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .reg_addr_i    (reg_addr_i),
   .reg_wr_en_i   (reg_wr_en_i),
   .reg_wr_data_i (reg_wr_data_i),
   .reg_rd_en_i   (reg_rd_en_i),
   .reg_rd_data_o (reg_rd_data_o),
   .cpu_irq_o     (cpu_irq_o),
   .pend_b        (pend_b),
   .en_b          (en_b),
   .rise_b        (rise_b)
);

// File: tb/irq_agg_top_tb_top.sv
`timescale 1ns/1ps
module irq_agg_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_lo = '0;
   logic [31:0] src_hi = '0;
   logic [7:0]  addr = '0;
   logic        wr = 1'b0;
   logic [31:0] wdata = '0;
   logic        rd = 1'b0;
   logic [31:0] rdata;
   logic        irq;

   int n_checks = 0;
   int n_errors = 0;
   bit started = 1'b0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   irq_agg_top dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .src_lo_i      (src_lo),
      .src_hi_i      (src_hi),
      .reg_addr_i    (addr),
      .reg_wr_en_i   (wr),
      .reg_wr_data_i (wdata),
      .reg_rd_en_i   (rd),
      .reg_rd_data_o (rdata),
      .cpu_irq_o     (irq)
   );

   // Behavioural reference: input history queue, per-bank words.
   bit [63:0] hist[$] = '{64'd0, 64'd0, 64'd0};
   bit [31:0] m_pend[2];
   bit [31:0] m_en[2];
   bit [31:0] m_rdata = '0;
   bit        m_irq = 1'b0;
   bit [7:0]  m_last_rd = 8'h00;

   function automatic string tag_for(input bit [7:0] a);
      if (a == 8'h10 || a == 8'h20) return "R4";
      if (a == 8'h14 || a == 8'h24) return "R5";
      return "R9";
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         hist = '{64'd0, 64'd0, 64'd0};
         m_pend = '{32'd0, 32'd0};
         m_en = '{32'd0, 32'd0};
         m_rdata = '0;
      end else begin
         bit [63:0] cur, old;
         cur = hist[1];
         old = hist[0];
         if (rd) begin
            m_last_rd = addr;
            case (addr)
               8'h10: m_rdata = m_pend[1] & m_en[1];
               8'h20: m_rdata = m_pend[0] & m_en[0];
               8'h14: m_rdata = m_en[1];
               8'h24: m_rdata = m_en[0];
               default: m_rdata = '0;
            endcase
         end
         for (int b = 0; b < 2; b++) begin
            bit [31:0] c, o, clr;
            c = cur[32*b +: 32];
            o = old[32*b +: 32];
            clr = (wr && addr == (b ? 8'h18 : 8'h28)) ? wdata : 32'd0;
            m_pend[b] = (m_pend[b] & ~clr & ~(o & ~c)) | (c & ~o);
            if (wr && addr == (b ? 8'h14 : 8'h24)) m_en[b] = wdata;
         end
         hist.push_back({src_hi, src_lo});
         void'(hist.pop_front());
      end
      m_irq = |((m_pend[0] & m_en[0]) | (m_pend[1] & m_en[1]));
      started = 1'b1;
   end

   // Per-cycle comparison, away from the active edge.
   always @(negedge clk) begin
      if (started && !done) begin
         n_checks++;
         if (irq !== m_irq) begin
            n_errors++;
            $display("FAIL R8 cycle compare irq: got %0b exp %0b at %0t", irq, m_irq, $time);
         end
         n_checks++;
         if (rdata !== m_rdata) begin
            n_errors++;
            $display("FAIL %s cycle compare rdata: got %h exp %h", tag_for(m_last_rd), rdata, m_rdata);
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: got %h exp %h at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic reg_write(input bit [7:0] a, input bit [31:0] d);
      addr = a; wdata = d; wr = 1'b1;
      tick(1);
      wr = 1'b0;
   endtask

   task automatic reg_read(input bit [7:0] a, output logic [31:0] d);
      addr = a; rd = 1'b1;
      tick(1);
      rd = 1'b0;
      d = rdata;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] r;
      tick(3);
      // r1_reset
      check("R1 irq after reset", {31'd0, irq}, 32'd0);
      check("R1 rdata after reset", rdata, 32'd0);
      rst_n = 1'b1;
      tick(1);
      reg_read(8'h24, r); check("R1 low mask reset", r, 32'd0);
      reg_read(8'h10, r); check("R1 high status reset", r, 32'd0);

      // R2: low bit 5
      reg_write(8'h24, 32'h0000_0020);
      src_lo[5] = 1'b1;
      tick(2); check("R2 irq before third edge", {31'd0, irq}, 32'd0);
      tick(1); check("R2 irq on third edge", {31'd0, irq}, 32'd1);
      reg_read(8'h20, r); check("R4 low masked status", r, 32'h0000_0020);
      reg_read(8'h10, r); check("R4 high masked status", r, 32'd0);

      // R6: acknowledge while still high
      reg_write(8'h28, 32'h0000_0020);
      check("R6 irq drops after ack", {31'd0, irq}, 32'd0);
      tick(10); check("R6 stays cleared while input high", {31'd0, irq}, 32'd0);
      reg_read(8'h20, r); check("R6 status after ack", r, 32'd0);

      // R3 and re-arm
      src_lo[5] = 1'b0; tick(4);
      src_lo[5] = 1'b1; tick(3);
      check("R2 re-arm after low", {31'd0, irq}, 32'd1);
      src_lo[5] = 1'b0;
      tick(2); check("R3 before third edge", {31'd0, irq}, 32'd1);
      tick(1); check("R3 cleared on fall", {31'd0, irq}, 32'd0);

      // R7: acknowledge on the same edge as the set
      reg_write(8'h24, 32'h0000_00A0);
      src_lo[7] = 1'b1;
      tick(2);
      addr = 8'h28; wdata = 32'h0000_0080; wr = 1'b1;
      tick(1);
      wr = 1'b0;
      reg_read(8'h20, r); check("R7 set beats ack", r, 32'h0000_0080);

      // R8: high bank and mask toggles
      reg_write(8'h24, 32'd0);
      check("R8 irq off after low mask cleared", {31'd0, irq}, 32'd0);
      src_hi[0] = 1'b1; tick(3);
      check("R8 pending high but masked", {31'd0, irq}, 32'd0);
      reg_write(8'h14, 32'h0000_0001);
      check("R8 irq rises next cycle on mask", {31'd0, irq}, 32'd1);
      reg_write(8'h14, 32'd0);
      check("R8 irq falls next cycle on mask", {31'd0, irq}, 32'd0);

      // R5
      reg_write(8'h14, 32'hA5A5_0001);
      reg_read(8'h14, r); check("R5 high mask readback", r, 32'hA5A5_0001);

      // R9
      reg_write(8'h2C, 32'hFFFF_FFFF);
      reg_write(8'h30, 32'hFFFF_FFFF);
      reg_write(8'h00, 32'hFFFF_FFFF);
      reg_read(8'h14, r); check("R9 high mask unchanged", r, 32'hA5A5_0001);
      reg_read(8'h24, r); check("R9 low mask unchanged", r, 32'd0);
      reg_read(8'h10, r); check("R9 high pending unchanged", r, 32'h0000_0001);
      reg_read(8'h18, r); check("R9 ack reads zero", r, 32'd0);
      reg_read(8'h2C, r); check("R9 reserved reads zero", r, 32'd0);
      reg_read(8'h40, r); check("R9 unmapped reads zero", r, 32'd0);
      reg_read(8'h10, r); check("R4 high status before R10", r, 32'h0000_0001);

      // R10: hold with no read
      src_hi[0] = 1'b0; tick(6);
      check("R10 rdata holds", rdata, 32'h0000_0001);
      check("R3 high fall drops irq", {31'd0, irq}, 32'd0);
      reg_read(8'h10, r); check("R4 high status after fall", r, 32'd0);

      // Mixed traffic against the reference model
      for (int i = 0; i < 3000; i++) begin
         int op;
         bit [7:0] addrs[10] = '{8'h10, 8'h14, 8'h18, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h30, 8'h00, 8'h44};
         op = $urandom_range(0, 9);
         if (op < 3) begin
            src_lo[$urandom_range(0, 31)] ^= 1'b1;
            src_hi[$urandom_range(0, 31)] ^= 1'b1;
         end
         addr  = addrs[$urandom_range(0, 9)];
         wdata = $urandom;
         wr    = (op == 4 || op == 5);
         rd    = (op >= 6);
         tick(1);
      end
      wr = 1'b0; rd = 1'b0;
      tick(5);
      finish_run();
   end
endmodule